// File: doc/BRIEF.md
# Parallel Link Bit Error Checker

This block qualifies one parallel backplane channel coming from a single source module. Every clock, the channel may present a 25-line word: 24 data lines plus one line that carries a parity bit. A transmitter under test sends a counting ramp on the data lines. The checker tests each accepted word in two ways. It checks the parity, with a polarity chosen by a configuration pin. It also compares the data against the ramp value it expects next. Each detected error is added to a single saturating error register that a host bus reads. One instance is built per source module, so a full crate of sixteen sources needs sixteen copies.

The ramp tracker synchronises itself. After a reset or a clear, the first word only seeds the expected value. If a word does not match, the tracker reloads its expectation from the word it received, so a single bad word cannot set off a long run of false errors. When line 0 carries a forwarded clock instead of parity, the parity check is switched off and only the ramp is checked.

The word input is a valid/ready stream. `in_ready` is held high at all times. A word is consumed on every clock edge where `in_valid` is high, and the sender never sees back-pressure. Cycles where `in_valid` is low leave all state unchanged. The control pins are plain levels.

Top module: `parlink_err_checker`

## Requirements
- R1: `in_ready` is 1 in every cycle, including during reset, and a word is accepted on every rising edge where `in_valid` is 1.
- R2: The word is laid out as follows: bit 0 is the parity line and bits 24:1 are the data. When `odd_par` is 0, the XOR of all 25 bits must be 0. When `odd_par` is 1, it must be 1. A word that breaks this rule is a parity error.
- R3: The first word accepted after a reset or a clear only loads the expected value and is never a ramp error. Each later word must carry data equal to the previous accepted data plus one, modulo 2^24, so 0xFFFFFF followed by 0x000000 is correct.
- R4: After a ramp mismatch, the next expected value is the received data plus one. A single corrupted word inside a correct ramp therefore gives exactly two ramp errors: one on that word and one on the word after it.
- R5: `locked` rises at the edge that accepts the second matching ramp word in a row. It falls at the edge that accepts a mismatching word, or on a clear.
- R6: At each accepted word, `err_count` grows by the number of enabled errors found in that word (0, 1 or 2). The new value is visible after that same edge.
- R7: `err_count` saturates at all ones and never wraps.
- R8: When `clr_cnt` is 1 at an edge, `err_count` goes to 0, `locked` goes to 0 and ramp synchronisation restarts. A word presented at that same edge is ignored.
- R9: While reset is asserted, `err_count` is 0 and `locked` is 0.
- R10: When `par_en` is 0, the parity line has no effect on `err_count`. When `ramp_en` is 0, ramp mismatches are not counted. The ramp tracker and `locked` keep running in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word on `in_word` is valid |
| in_ready | output | 1 | Always 1; the checker never applies back-pressure |
| in_word | input | 25 | Bit 0 is the parity or forwarded-clock line; bits 24:1 are the data |
| par_en | input | 1 | Count parity errors |
| ramp_en | input | 1 | Count ramp errors |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| clr_cnt | input | 1 | Synchronous clear of the counter and the ramp sync |
| err_count | output | CNT_W (32) | Accumulated error count for the host read port |
| locked | output | 1 | The ramp tracker is synchronised |

## Verification
The bench runs the ramp across the 0xFFFFFF-to-zero boundary. A tracker that does not wrap modulo 2^24 would log an error there. It injects a single corrupted word and expects exactly two ramp errors: a tracker that never resynchronises would count endlessly, and one that keeps its old expectation would count only one. It presents corrupt data and a bad parity bit in the same word to catch an accumulator that adds only one per word. It also raises a clear together with a valid word, which shows whether that word leaks into the count or into the seed. The bench shrinks the counter and pushes it past its maximum to expose any wrap back to zero. Finally, it toggles the parity line with parity checking off, in the way a forwarded clock would.

// File: rtl/plerr_pkg.sv
package plerr_pkg;
  localparam int unsigned DATA_W = 24;
  localparam int unsigned WORD_W = DATA_W + 1;
  localparam int unsigned INC_W  = 2;

  typedef logic [DATA_W-1:0] ramp_t;

  typedef struct packed {
    logic par_en;
    logic ramp_en;
    logic odd_par;
  } chk_cfg_t;
endpackage

// File: rtl/plerr_parity.sv
module plerr_parity #(
  parameter int unsigned WORD_W = 25
) (
  input  logic [WORD_W-1:0] word,
  input  logic              odd_par,
  output logic              par_err
);
  logic [WORD_W-1:0] fold;

  // running XOR across the lines, lowest bit first
  assign fold[0] = word[0];
  for (genvar i = 1; i < WORD_W; i++) begin : g_fold
    assign fold[i] = fold[i-1] ^ word[i];
  end

  assign par_err = fold[WORD_W-1] ^ odd_par;
endmodule

// File: rtl/plerr_ramp.sv
module plerr_ramp #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              clr,
  input  logic [DATA_W-1:0] data,
  output logic              ramp_err,
  output logic              locked
);
  logic [DATA_W-1:0] expect_q;
  logic              seeded_q;
  logic              run_q;
  logic              locked_q;
  logic              hit;

  assign hit      = (data == expect_q);
  assign ramp_err = take & seeded_q & ~hit;
  assign locked   = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q <= '0;
      seeded_q <= 1'b0;
      run_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (clr) begin
      seeded_q <= 1'b0;
      run_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (take) begin
      // the next value is always predicted from what actually arrived
      expect_q <= data + 1'b1;
      seeded_q <= 1'b1;
      if (seeded_q) begin
        if (hit) begin
          run_q    <= 1'b1;
          locked_q <= locked_q | run_q;
        end else begin
          run_q    <= 1'b0;
          locked_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/plerr_accum.sv
module plerr_accum #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum   = {1'b0, cnt_q} + {{(CNT_W+1-INC_W){1'b0}}, inc};
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (sum[CNT_W]) cnt_q <= '1;
    else                 cnt_q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/parlink_err_checker.sv
module parlink_err_checker
  import plerr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              par_en,
  input  logic              ramp_en,
  input  logic              odd_par,
  input  logic              clr_cnt,
  output logic [CNT_W-1:0]  err_count,
  output logic              locked
);
  chk_cfg_t         cfg;
  logic             take;
  logic             par_err;
  logic             ramp_err;
  logic [INC_W-1:0] inc;
  ramp_t            data;

  assign cfg      = '{par_en: par_en, ramp_en: ramp_en, odd_par: odd_par};
  assign in_ready = 1'b1;
  assign take     = in_valid & ~clr_cnt;
  assign data     = in_word[WORD_W-1:1];

  plerr_parity #(.WORD_W(WORD_W)) u_par (
    .word    (in_word),
    .odd_par (cfg.odd_par),
    .par_err (par_err)
  );

  plerr_ramp #(.DATA_W(DATA_W)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .clr      (clr_cnt),
    .data     (data),
    .ramp_err (ramp_err),
    .locked   (locked)
  );

  assign inc = {1'b0, take & cfg.par_en & par_err}
             + {1'b0, cfg.ramp_en & ramp_err};

  plerr_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_cnt),
    .inc   (inc),
    .count (err_count)
  );
endmodule

// File: rtl/plerr_checker.sv
module plerr_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             clr_cnt,
  input logic [CNT_W-1:0] err_count,
  input logic             locked
);
  // R6/R7: without a clear the count never drops and grows by at most two
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_cnt) |-> ((err_count - $past(err_count)) <= CNT_W'(2)))
    else $error("count stepped backwards or too far");

  // R8: a clear leaves a zero count
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_cnt) |-> (err_count == '0))
    else $error("count not zero after clear");

  // R1/R6: no word and no clear means no change
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_valid) && !$past(clr_cnt)) |-> $stable(err_count))
    else $error("count moved without a word");

  // R5: lock falls only on a word or a clear
  a_r5_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(in_valid || clr_cnt))
    else $error("lock dropped spontaneously");

  // R5: lock rises only on an accepted word
  a_r5_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid && !clr_cnt))
    else $error("lock rose without a word");
endmodule

bind parlink_err_checker plerr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .clr_cnt   (clr_cnt),
  .err_count (err_count),
  .locked    (locked)
);

// File: tb/parlink_err_checker_tb.sv
module parlink_err_checker_tb;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [24:0]   in_word = '0;
  logic          par_en = 1'b1, ramp_en = 1'b1, odd_par = 1'b0, clr_cnt = 1'b0;
  logic [CW-1:0] err_count;
  logic          locked;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R9";

  // reference model state
  bit          m_seed = 0, m_run = 0, m_lock = 0;
  logic [23:0] m_exp = '0;
  int          m_cnt = 0;

  always #10 clk = ~clk;

  parlink_err_checker #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .par_en(par_en), .ramp_en(ramp_en), .odd_par(odd_par),
    .clr_cnt(clr_cnt), .err_count(err_count), .locked(locked));

  function automatic logic [24:0] mk(logic [23:0] d, bit badp);
    return {d, (^d) ^ odd_par ^ badp};
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // at a negedge: drive, advance model across the next posedge, compare
  task automatic cyc(bit v, logic [24:0] w, bit c);
    int inc = 0;
    bit perr, hit;
    in_valid = v; in_word = w; clr_cnt = c;
    if (c) begin
      m_cnt = 0; m_seed = 0; m_run = 0; m_lock = 0;
    end else if (v) begin
      perr = ((^w) != odd_par);
      if (par_en && perr) inc++;
      if (m_seed) begin
        hit = (w[24:1] == m_exp);
        if (!hit && ramp_en) inc++;
        if (hit) begin m_lock = m_lock | m_run; m_run = 1; end
        else begin m_lock = 0; m_run = 0; end
      end
      m_seed = 1;
      m_exp = w[24:1] + 24'd1;
      m_cnt = (m_cnt + inc > CMAX) ? CMAX : m_cnt + inc;
    end
    @(negedge clk);
    check(tag, int'(err_count), m_cnt, "err_count");
    check(tag, int'(locked), int'(m_lock), "locked");
    check("R1", int'(in_ready), 1, "in_ready");
  endtask

  task automatic ramp(logic [23:0] start, int n);
    for (int i = 0; i < n; i++) cyc(1, mk(start + 24'(i), 0), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    @(negedge clk);
    tag = "R9";
    check("R9", int'(err_count), 0, "count in reset");
    check("R9", int'(locked), 0, "locked in reset");
    check("R1", int'(in_ready), 1, "ready in reset");
    @(negedge clk); rst_n = 1'b1;

    // R3: clean ramp across the wrap point, lock expected (R5)
    tag = "R3";
    ramp(24'hFFFFF9, 14);
    check("R5", int'(locked), 1, "locked after clean ramp");

    // R1: gaps in valid
    tag = "R1";
    v = 24'h000007;
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 1) cyc(0, 25'h1ABCDE, 0);
      else begin cyc(1, mk(v, 0), 0); v++; end
    end

    // R4: one corrupted word -> two errors
    tag = "R4";
    cyc(1, mk(v ^ 24'h000400, 0), 0); v++;
    ramp(v, 6); v += 6;

    // R2: parity errors, even then odd polarity
    tag = "R2";
    cyc(1, mk(v, 1), 0); v++;
    ramp(v, 3); v += 3;
    odd_par = 1'b1;
    ramp(v, 3); v += 3;
    cyc(1, mk(v, 1), 0); v++;

    // R6: both errors in one word
    tag = "R6";
    cyc(1, mk(v ^ 24'h800000, 1), 0); v++;
    ramp(v, 4); v += 4;

    // R8: clear together with a valid bad word, then reseed
    tag = "R8";
    cyc(1, mk(24'h123456, 1), 1);
    cyc(1, mk(24'h00ABCD, 0), 0);
    ramp(24'h00ABCE, 4);

    // R10: line 0 as a forwarded clock, parity off
    tag = "R10";
    par_en = 1'b0;
    v = 24'h00ABD2;
    for (int i = 0; i < 8; i++) begin
      cyc(1, {v, 1'(i & 1)}, 0); v++;
    end
    ramp_en = 1'b0;
    cyc(1, {24'h555555, 1'b0}, 0);
    cyc(1, {24'h000001, 1'b1}, 0);
    ramp_en = 1'b1; par_en = 1'b1;
    ramp(24'h000002, 3);

    // R7: saturation of the reduced counter
    tag = "R7";
    for (int i = 0; i < 45; i++) cyc(1, mk(24'(i * 7), 1), 0);
    check("R7", int'(err_count), CMAX, "saturated count");
    cyc(1, mk(24'h0, 1), 0);
    check("R7", int'(err_count), CMAX, "holds at max");

    tag = "R8";
    cyc(0, '0, 1);
    check("R8", int'(err_count), 0, "cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule